// File: doc/BRIEF.md
# Three-Row Rotating Line Buffer

This block holds the three most recent feature-map rows that a 3×3 sliding-window engine needs. Each row lives in its own on-chip queue as a run of wide words: one word carries a group of channel lanes at one column position. Channels are the fastest-moving axis, so column `c`, channel group `g` sits at word address `c * groups + g`. Rows arrive on a write stream and fill whichever queue is free. The window engine reads the resident rows repeatedly by naming a logical window row (top, middle or bottom) and a word address. It never names a physical queue.

At the end of each output row the engine pulses `row_done`. With stride 1 the oldest row is released and the other two stay resident for the next output row. With stride 2 the two oldest rows are released and only the newest stays. A 2-bit modulo-3 pointer records which physical queue currently holds the top row. The three queues therefore swap roles without moving any data. The next incoming row prefetches into a freed queue. A write aimed at a queue whose contents are still needed is held off by dropping `wr_ready`.

Top module: `tri_row_buffer`

## Requirements
- R1: After reset `wr_ready` is 1, `win_ready` is 0, `reuse_flags` is 3'b000 and `rd_valid` is 0.
- R2: A row is `cfg_width * cfg_groups` accepted words long, with a length between 1 and the queue depth. Words are accepted on cycles where `wr_valid` and `wr_ready` are both high. Rows fill physical queues 0, 1, 2 in order from reset, and then wrap modulo 3.
- R3: `win_ready` is 1 exactly when all three queues hold a complete row that has not been released.
- R4: `wr_ready` is 0 while the queue next in the fill order still holds an unreleased row. Words offered while `wr_ready` is 0 are not stored.
- R5: A read with `rd_en` high returns the word on `rd_data`, with `rd_valid` high, in the following cycle. Only one path is read per cycle. `rd_path` 0, 1 and 2 select the oldest, middle and newest resident row.
- R6: A returned word is bit-identical to the word written at that address. Lane k of a word occupies bits [k*LANE_W +: LANE_W], and column `c`, group `g` is at address `c * cfg_groups + g`.
- R7: With `cfg_stride2` = 0, an accepted `row_done` releases the oldest row and keeps the other two. The next row written becomes path 2, and the two kept rows move to paths 0 and 1.
- R8: With `cfg_stride2` = 1, an accepted `row_done` releases the two oldest rows and keeps the newest as path 0. The next two rows written become paths 1 and 2.
- R9: `reuse_flags` bit q is 1 for physical queue q once its row survives a `row_done`. The bit clears when that row is released. A newly written row starts with its bit at 0.
- R10: `row_done` is ignored while `win_ready` is 0. No row is released, and `reuse_flags` and `wr_ready` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | WIDTH_W | Feature-map width in columns |
| cfg_groups | input | GRP_W | Number of channel groups per column |
| cfg_stride2 | input | 1 | 0: stride 1, 1: stride 2 |
| wr_valid | input | 1 | Write stream word valid |
| wr_data | input | LANES*LANE_W | Write stream word |
| wr_ready | output | 1 | Write stream may advance |
| row_done | input | 1 | End of one output row |
| win_ready | output | 1 | Three rows resident |
| reuse_flags | output | 3 | Per physical queue: row kept across a row_done |
| rd_en | input | 1 | Read request |
| rd_path | input | 2 | Logical window row 0..2 |
| rd_addr | input | $clog2(MAX_WORDS) | Word address within the row |
| rd_valid | output | 1 | rd_data holds the requested word |
| rd_data | output | LANES*LANE_W | Read word |

## Verification
The bench builds the block with 4 lanes of 16 bits and 16-word queues. Small rows of 6 words can then cycle through every queue several times under both strides within a few hundred cycles. A 16-word row reaches the last address of a queue. The two strides are exercised one after the other on the same live state, so the role pointer is checked across its modulo-3 wrap and across a switch of stride.

// File: rtl/lb_pkg.sv
package lb_pkg;

    typedef enum logic {
        STEP_ONE = 1'b0,
        STEP_TWO = 1'b1
    } stride_e;

    function automatic logic [1:0] ring_add(input logic [1:0] p, input logic [1:0] step);
        logic [2:0] s;
        s = {1'b0, p} + {1'b0, step};
        if (s >= 3'd3) s = s - 3'd3;
        if (s >= 3'd3) s = s - 3'd3;
        return s[1:0];
    endfunction

endpackage

// File: rtl/lb_row_queue.sv
module lb_row_queue #(
    parameter int WORD_W = 512,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end

endmodule

// File: rtl/lb_ring_ctrl.sv
module lb_ring_ctrl
    import lb_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int WIDTH_W = 6,
    parameter int GRP_W   = 3,
    localparam int AW     = $clog2(DEPTH),
    localparam int LEN_W  = WIDTH_W + GRP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WIDTH_W-1:0] cfg_width,
    input  logic [GRP_W-1:0]   cfg_groups,
    input  logic               cfg_stride2,
    input  logic               wr_valid,
    input  logic               row_done,
    output logic               wr_ready,
    output logic [2:0]         wr_onehot,
    output logic [AW-1:0]      wr_addr,
    output logic               win_ready,
    output logic [1:0]         top_ptr,
    output logic [2:0]         reuse_flags
);

    typedef struct packed {
        logic [1:0]       top;
        logic [1:0]       fill;
        logic [LEN_W-1:0] cnt;
        logic [2:0]       loaded;
        logic [2:0]       reuse;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic [LEN_W-1:0] row_len;
    logic             accept;
    logic [1:0]       p1, p2;
    stride_e          stride;

    always_comb begin
        st_d     = st_q;
        stride   = stride_e'(cfg_stride2);
        row_len  = LEN_W'(cfg_width) * LEN_W'(cfg_groups);
        wr_ready = !st_q.loaded[st_q.fill];
        accept   = wr_valid && wr_ready;
        p1       = ring_add(st_q.top, 2'd1);
        p2       = ring_add(st_q.top, 2'd2);

        if (accept) begin
            if (st_q.cnt == row_len - LEN_W'(1)) begin
                st_d.cnt                = '0;
                st_d.loaded[st_q.fill]  = 1'b1;
                st_d.reuse[st_q.fill]   = 1'b0;
                st_d.fill               = ring_add(st_q.fill, 2'd1);
            end else begin
                st_d.cnt = st_q.cnt + LEN_W'(1);
            end
        end

        if (row_done && (&st_q.loaded)) begin
            st_d.loaded[st_q.top] = 1'b0;
            st_d.reuse[st_q.top]  = 1'b0;
            st_d.reuse[p2]        = 1'b1;
            if (stride == STEP_TWO) begin
                st_d.loaded[p1] = 1'b0;
                st_d.reuse[p1]  = 1'b0;
                st_d.top        = p2;
            end else begin
                st_d.reuse[p1]  = 1'b1;
                st_d.top        = p1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        wr_onehot = '0;
        wr_onehot[st_q.fill] = accept;
    end

    assign wr_addr     = st_q.cnt[AW-1:0];
    assign win_ready   = &st_q.loaded;
    assign top_ptr     = st_q.top;
    assign reuse_flags = st_q.reuse;

endmodule

// File: rtl/tri_row_buffer.sv
module tri_row_buffer
    import lb_pkg::*;
#(
    parameter int LANES     = 32,
    parameter int LANE_W    = 16,
    parameter int MAX_WORDS = 64,
    parameter int WIDTH_W   = 6,
    parameter int GRP_W     = 3,
    localparam int WORD_W   = LANES * LANE_W,
    localparam int AW       = $clog2(MAX_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WIDTH_W-1:0] cfg_width,
    input  logic [GRP_W-1:0]   cfg_groups,
    input  logic               cfg_stride2,
    input  logic               wr_valid,
    input  logic [WORD_W-1:0]  wr_data,
    output logic               wr_ready,
    input  logic               row_done,
    output logic               win_ready,
    output logic [2:0]         reuse_flags,
    input  logic               rd_en,
    input  logic [1:0]         rd_path,
    input  logic [AW-1:0]      rd_addr,
    output logic               rd_valid,
    output logic [WORD_W-1:0]  rd_data
);

    typedef struct packed {
        logic [1:0] sel;
        logic       vld;
    } rsel_t;

    logic [2:0]        wr_onehot;
    logic [AW-1:0]     wr_addr;
    logic [1:0]        top_ptr;
    logic [1:0]        rd_phys;
    logic [WORD_W-1:0] q_rdata [3];
    rsel_t             rs_d, rs_q;

    lb_ring_ctrl #(
        .DEPTH   (MAX_WORDS),
        .WIDTH_W (WIDTH_W),
        .GRP_W   (GRP_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_width   (cfg_width),
        .cfg_groups  (cfg_groups),
        .cfg_stride2 (cfg_stride2),
        .wr_valid    (wr_valid),
        .row_done    (row_done),
        .wr_ready    (wr_ready),
        .wr_onehot   (wr_onehot),
        .wr_addr     (wr_addr),
        .win_ready   (win_ready),
        .top_ptr     (top_ptr),
        .reuse_flags (reuse_flags)
    );

    assign rd_phys = ring_add(top_ptr, rd_path);

    for (genvar q = 0; q < 3; q++) begin : g_queue
        lb_row_queue #(
            .WORD_W (WORD_W),
            .DEPTH  (MAX_WORDS)
        ) u_queue (
            .clk   (clk),
            .we    (wr_onehot[q]),
            .waddr (wr_addr),
            .wdata (wr_data),
            .re    (rd_en && (rd_phys == 2'(q))),
            .raddr (rd_addr),
            .rdata (q_rdata[q])
        );
    end

    always_comb begin
        rs_d     = rs_q;
        rs_d.vld = rd_en;
        if (rd_en) rs_d.sel = rd_phys;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign rd_valid = rs_q.vld;
    assign rd_data  = q_rdata[rs_q.sel];

endmodule

// File: rtl/tri_row_buffer_chk.sv
module tri_row_buffer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_ready,
    input logic       win_ready,
    input logic       row_done,
    input logic       cfg_stride2,
    input logic       rd_en,
    input logic       rd_valid,
    input logic [2:0] reuse_flags
);

    p_full_stalls_r4: assert property (@(posedge clk) disable iff (!rst_n)
        win_ready |-> !wr_ready);

    p_read_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    p_keep_two_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (row_done && win_ready && !cfg_stride2) |=> ($countones(reuse_flags) == 2));

    p_keep_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (row_done && win_ready && cfg_stride2) |=> ($countones(reuse_flags) == 1));

    p_release_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (row_done && win_ready) |=> (!win_ready && wr_ready));

    p_ignored_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (row_done && !win_ready) |=> $stable(reuse_flags));

endmodule

bind tri_row_buffer tri_row_buffer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_ready    (wr_ready),
    .win_ready   (win_ready),
    .row_done    (row_done),
    .cfg_stride2 (cfg_stride2),
    .rd_en       (rd_en),
    .rd_valid    (rd_valid),
    .reuse_flags (reuse_flags)
);

// File: tb/tri_row_buffer_bench.sv
module tri_row_buffer_bench;

    localparam int LANES  = 4;
    localparam int LANE_W = 16;
    localparam int WORDS  = 16;
    localparam int WW     = 4;
    localparam int GW     = 2;
    localparam int DW     = LANES * LANE_W;
    localparam int AW     = $clog2(WORDS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [WW-1:0] cfg_width = 4'd3;
    logic [GW-1:0] cfg_groups = 2'd2;
    logic          cfg_stride2 = 1'b0;
    logic          wr_valid = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_ready;
    logic          row_done = 1'b0;
    logic          win_ready;
    logic [2:0]    reuse_flags;
    logic          rd_en = 1'b0;
    logic [1:0]    rd_path = '0;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    tri_row_buffer #(
        .LANES (LANES), .LANE_W (LANE_W), .MAX_WORDS (WORDS),
        .WIDTH_W (WW), .GRP_W (GW)
    ) u_tri_row_buffer (
        .clk (clk), .rst_n (rst_n), .cfg_width (cfg_width), .cfg_groups (cfg_groups),
        .cfg_stride2 (cfg_stride2), .wr_valid (wr_valid), .wr_data (wr_data),
        .wr_ready (wr_ready), .row_done (row_done), .win_ready (win_ready),
        .reuse_flags (reuse_flags), .rd_en (rd_en), .rd_path (rd_path),
        .rd_addr (rd_addr), .rd_valid (rd_valid), .rd_data (rd_data)
    );

    function automatic logic [DW-1:0] pat(input int r, input int a);
        logic [DW-1:0] w;
        for (int k = 0; k < LANES; k++) w[k*LANE_W +: LANE_W] = 16'(r * 256 + a * 8 + k);
        return w;
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic write_row(input int r, input int len);
        for (int i = 0; i < len; i++) begin
            wr_valid = 1'b1;
            wr_data  = pat(r, i);
            while (!wr_ready) @(negedge clk);
            @(negedge clk);
        end
        wr_valid = 1'b0;
    endtask

    task automatic read_chk(input string tag, input int path, input int addr, input int r);
        rd_en   = 1'b1;
        rd_path = 2'(path);
        rd_addr = AW'(addr);
        @(negedge clk);
        rd_en = 1'b0;
        check({tag, " valid"}, DW'(rd_valid), DW'(1));
        check({tag, " data"}, rd_data, pat(r, addr));
    endtask

    task automatic pulse_done();
        row_done = 1'b1;
        @(negedge clk);
        row_done = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 wr_ready", DW'(wr_ready), DW'(1));
        check("R1 win_ready", DW'(win_ready), DW'(0));
        check("R1 reuse", DW'(reuse_flags), DW'(0));
        check("R1 rd_valid", DW'(rd_valid), DW'(0));
    endtask

    task automatic t_fill();
        write_row(0, 6);
        write_row(1, 6);
        check("R3 not ready after two rows", DW'(win_ready), DW'(0));
        write_row(2, 6);
        check("R3 ready after three rows", DW'(win_ready), DW'(1));
        read_chk("R5 path0", 0, 5, 0);
        read_chk("R6 path1", 1, 3, 1);
        read_chk("R5 path2", 2, 0, 2);
    endtask

    task automatic t_backpressure();
        check("R4 stalled", DW'(wr_ready), DW'(0));
        wr_valid = 1'b1;
        wr_data  = pat(9, 0);
        repeat (3) @(negedge clk);
        wr_valid = 1'b0;
        check("R4 still stalled", DW'(wr_ready), DW'(0));
        read_chk("R4 no overwrite", 0, 0, 0);
    endtask

    task automatic t_stride1();
        pulse_done();
        check("R7 reuse flags", DW'(reuse_flags), DW'(3'b110));
        check("R9 freed", DW'(wr_ready), DW'(1));
        write_row(3, 6);
        read_chk("R7 path0", 0, 2, 1);
        read_chk("R7 path1", 1, 4, 2);
        read_chk("R7 path2", 2, 5, 3);
        check("R9 new row flag clear", DW'(reuse_flags), DW'(3'b110));
        pulse_done();
        check("R9 rotate flags", DW'(reuse_flags), DW'(3'b101));
    endtask

    task automatic t_ignored();
        pulse_done();
        check("R10 flags", DW'(reuse_flags), DW'(3'b101));
        check("R10 wr_ready", DW'(wr_ready), DW'(1));
        check("R10 win_ready", DW'(win_ready), DW'(0));
        write_row(4, 6);
        read_chk("R10 path0 kept", 0, 1, 2);
        read_chk("R10 path2", 2, 1, 4);
    endtask

    task automatic t_stride2();
        cfg_stride2 = 1'b1;
        pulse_done();
        check("R8 flags", DW'(reuse_flags), DW'(3'b010));
        write_row(5, 6);
        check("R8 one row not enough", DW'(win_ready), DW'(0));
        write_row(6, 6);
        read_chk("R8 path0", 0, 4, 4);
        read_chk("R8 path1", 1, 4, 5);
        read_chk("R8 path2", 2, 4, 6);
        pulse_done();
        check("R8 wrap flags", DW'(reuse_flags), DW'(3'b001));
    endtask

    task automatic t_full_depth();
        cfg_width  = 4'd8;
        cfg_groups = 2'd2;
        write_row(7, 16);
        check("R2 one long row", DW'(win_ready), DW'(0));
        write_row(8, 16);
        check("R2 ready", DW'(win_ready), DW'(1));
        read_chk("R2 last addr path1", 1, 15, 7);
        read_chk("R6 last addr path2", 2, 15, 8);
        read_chk("R8 kept path0", 0, 0, 6);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_backpressure();
        t_stride1();
        t_ignored();
        t_stride2();
        t_full_depth();
        finish_run();
    end

endmodule